// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This stage sits between instruction decode and issue. An ordinary scalar instruction arrives from decode, optionally marked with a vectorisation tag and a vector length. Untagged instructions go straight to issue one cycle later. A tagged instruction is expanded into a loop of scalar element operations. Each element operation reuses the original opcode. The stage holds the main program counter while the loop runs.

A parameter sets how many lanes go out per cycle. Each cycle, one group of consecutive elements leaves in ascending order. When the vector length is not a multiple of the lane count, the unused lanes of the final group are masked off. Register numbers of operands marked as vector are offset by the element index. Operands marked as scalar keep their base number. Both sides of the stage use valid/ready handshakes.

Top module: `velem_seq`

## Requirements
- R1: After reset, `out_valid` and `pc_stall` are 0 and `in_ready` is 1.
- R2: An instruction accepted with `in_tag`=0 appears at the outputs in the next cycle as one group. In that group only lane 0 is enabled (`out_lane_en`=1), `out_last`=1, lane 0 has index 0, and the opcode and register numbers are unchanged. `pc_stall` stays 0.
- R3: For a tagged instruction with nonzero length, `pc_stall` is 1 in every cycle in which one of its groups is presented. It drops in the cycle after its final group is accepted.
- R4: Every group produced from one tagged instruction carries that instruction's opcode on `out_opc`.
- R5: Groups leave in ascending element order. Group g carries element index g*LANES+i on lane i, where lane i occupies bits [i*VL_W +: VL_W] of `out_idx`.
- R6: In each group, lane i is enabled (`out_lane_en[i]`) only when its index is below the vector length, so the enabled lanes form a prefix starting at lane 0. `out_last` is 1 only on the final group.
- R7: In each lane of a tagged group, the register numbers are formed as follows. An operand whose select bit is 1 gets its base number plus the element index, modulo 2^REG_W. The select bits are `in_vsel` bit 0 for rd, bit 1 for rs1 and bit 2 for rs2. An operand whose select bit is 0 keeps its base number.
- R8: A tagged instruction with vector length 0 is accepted, produces no output group, and never raises `pc_stall`.
- R9: While `out_valid`=1 and `out_ready`=0, all group outputs hold steady into the next cycle.
- R10: `in_ready` is 0 whenever a group is presented, unless that group is final and accepted in the same cycle.

Lane fields of `out_idx`, `out_rd`, `out_rs1` and `out_rs2` are packed lane i at bits [i*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Stage can accept an instruction |
| in_tag | input | 1 | Vectorisation tag |
| in_vl | input | VL_W | Vector length in elements |
| in_opc | input | OPC_W | Scalar opcode |
| in_rd | input | REG_W | Base destination register |
| in_rs1 | input | REG_W | Base source register 1 |
| in_rs2 | input | REG_W | Base source register 2 |
| in_vsel | input | 3 | Vector/scalar marks: bit0 rd, bit1 rs1, bit2 rs2 |
| out_valid | output | 1 | Element group valid |
| out_ready | input | 1 | Issue accepts the group |
| out_opc | output | OPC_W | Opcode of every element operation |
| out_lane_en | output | LANES | Per-lane enable |
| out_idx | output | LANES*VL_W | Per-lane element index |
| out_rd | output | LANES*REG_W | Per-lane destination register |
| out_rs1 | output | LANES*REG_W | Per-lane source register 1 |
| out_rs2 | output | LANES*REG_W | Per-lane source register 2 |
| out_last | output | 1 | Group is the final one of its instruction |
| pc_stall | output | 1 | Hold the main program counter |

## Verification
The loop state is a single group index. If it is corrupted, the lane indices and the offset register numbers of the very next group are wrong. A skipped, repeated or truncated group then leaves the expected-item queue out of step, and every following comparison is wrong as well. A fault in the valid or last tracking shows up on the first handshake cycle in several ways: a premature or late drop of `pc_stall`, `in_ready` rising while groups are still pending, or an output appearing for a zero-length instruction. Random backpressure exposes any change of the outputs while they are stalled one cycle after it occurs.

// File: rtl/velem_pkg.sv
package velem_pkg;
  // Bit positions of the operand vector/scalar select field
  localparam int unsigned SEL_RD  = 0;
  localparam int unsigned SEL_RS1 = 1;
  localparam int unsigned SEL_RS2 = 2;
  localparam int unsigned SEL_W   = 3;

  function automatic bit lanes_legal(input int unsigned n);
    return (n == 1) || (n == 2) || (n == 4) || (n == 8);
  endfunction
endpackage

// File: rtl/velem_ctrl.sv
module velem_ctrl
  import velem_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned VL_W  = 6,
  parameter int unsigned REG_W = 5,
  parameter int unsigned OPC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_tag,
  input  logic [VL_W-1:0]  in_vl,
  input  logic [OPC_W-1:0] in_opc,
  input  logic [REG_W-1:0] in_rd,
  input  logic [REG_W-1:0] in_rs1,
  input  logic [REG_W-1:0] in_rs2,
  input  logic [SEL_W-1:0] in_vsel,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             grp_valid,
  output logic             grp_last,
  output logic [VL_W-1:0]  grp_base,
  output logic [VL_W-1:0]  cur_vl,
  output logic             cur_tag,
  output logic [OPC_W-1:0] cur_opc,
  output logic [REG_W-1:0] cur_rd,
  output logic [REG_W-1:0] cur_rs1,
  output logic [REG_W-1:0] cur_rs2,
  output logic [SEL_W-1:0] cur_vsel,
  output logic             pc_stall
);
  localparam logic [VL_W:0] STEP = (VL_W+1)'(LANES);

  logic             valid_q, valid_d;
  logic [VL_W-1:0]  idx_q, idx_d;
  logic [VL_W:0]    grp_end;
  logic             last_c, ready_c, load_en, adv_en;
  logic             tag_q;
  logic [VL_W-1:0]  vl_q;
  logic [OPC_W-1:0] opc_q;
  logic [REG_W-1:0] rd_q, rs1_q, rs2_q;
  logic [SEL_W-1:0] vsel_q;

  // next-state logic
  always_comb begin
    grp_end = {1'b0, idx_q} + STEP;
    last_c  = !tag_q || (grp_end >= {1'b0, vl_q});
    ready_c = !valid_q || (out_ready && last_c);
    load_en = in_valid && ready_c;
    adv_en  = valid_q && out_ready;
    valid_d = valid_q;
    idx_d   = idx_q;
    if (load_en) begin
      valid_d = !(in_tag && (in_vl == '0));
      idx_d   = '0;
    end else if (adv_en) begin
      if (last_c) valid_d = 1'b0;
      else        idx_d   = grp_end[VL_W-1:0];
    end
  end

  // loop state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  // instruction payload, captured on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= 1'b0;
      vl_q   <= '0;
      opc_q  <= '0;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      vsel_q <= '0;
    end else if (load_en) begin
      tag_q  <= in_tag;
      vl_q   <= in_vl;
      opc_q  <= in_opc;
      rd_q   <= in_rd;
      rs1_q  <= in_rs1;
      rs2_q  <= in_rs2;
      vsel_q <= in_vsel;
    end
  end

  assign in_ready  = ready_c;
  assign grp_valid = valid_q;
  assign grp_last  = last_c;
  assign grp_base  = idx_q;
  assign cur_vl    = vl_q;
  assign cur_tag   = tag_q;
  assign cur_opc   = opc_q;
  assign cur_rd    = rd_q;
  assign cur_rs1   = rs1_q;
  assign cur_rs2   = rs2_q;
  assign cur_vsel  = vsel_q;
  assign pc_stall  = valid_q && tag_q;
endmodule

// File: rtl/velem_lane.sv
module velem_lane
  import velem_pkg::*;
#(
  parameter int unsigned LANE  = 0,
  parameter int unsigned VL_W  = 6,
  parameter int unsigned REG_W = 5
) (
  input  logic [VL_W-1:0]  base,
  input  logic [VL_W-1:0]  vl,
  input  logic             tag,
  input  logic [REG_W-1:0] rd,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic [SEL_W-1:0] vsel,
  output logic             en,
  output logic [VL_W-1:0]  idx,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rs1_o,
  output logic [REG_W-1:0] rs2_o
);
  localparam logic [VL_W:0] OFS = (VL_W+1)'(LANE);

  logic [VL_W:0]    pos;
  logic [REG_W-1:0] step;

  always_comb begin
    pos   = {1'b0, base} + OFS;
    idx   = pos[VL_W-1:0];
    step  = REG_W'(idx);
    en    = tag ? (pos < {1'b0, vl}) : (LANE == 0);
    rd_o  = rd  + ((tag && vsel[SEL_RD])  ? step : '0);
    rs1_o = rs1 + ((tag && vsel[SEL_RS1]) ? step : '0);
    rs2_o = rs2 + ((tag && vsel[SEL_RS2]) ? step : '0);
  end
endmodule

// File: rtl/velem_seq.sv
module velem_seq
  import velem_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned VL_W  = 6,
  parameter int unsigned REG_W = 5,
  parameter int unsigned OPC_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_tag,
  input  logic [VL_W-1:0]        in_vl,
  input  logic [OPC_W-1:0]       in_opc,
  input  logic [REG_W-1:0]       in_rd,
  input  logic [REG_W-1:0]       in_rs1,
  input  logic [REG_W-1:0]       in_rs2,
  input  logic [2:0]             in_vsel,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OPC_W-1:0]       out_opc,
  output logic [LANES-1:0]       out_lane_en,
  output logic [LANES*VL_W-1:0]  out_idx,
  output logic [LANES*REG_W-1:0] out_rd,
  output logic [LANES*REG_W-1:0] out_rs1,
  output logic [LANES*REG_W-1:0] out_rs2,
  output logic                   out_last,
  output logic                   pc_stall
);
  logic [VL_W-1:0]  grp_base, cur_vl;
  logic             cur_tag;
  logic [REG_W-1:0] cur_rd, cur_rs1, cur_rs2;
  logic [SEL_W-1:0] cur_vsel;

  if (!lanes_legal(LANES)) begin : g_bad_lanes
    initial $error("LANES must be 1, 2, 4 or 8");
  end

  velem_ctrl #(
    .LANES(LANES), .VL_W(VL_W), .REG_W(REG_W), .OPC_W(OPC_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_tag(in_tag), .in_vl(in_vl), .in_opc(in_opc),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_vsel(in_vsel),
    .out_ready(out_ready), .in_ready(in_ready),
    .grp_valid(out_valid), .grp_last(out_last), .grp_base(grp_base),
    .cur_vl(cur_vl), .cur_tag(cur_tag), .cur_opc(out_opc),
    .cur_rd(cur_rd), .cur_rs1(cur_rs1), .cur_rs2(cur_rs2),
    .cur_vsel(cur_vsel), .pc_stall(pc_stall)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    velem_lane #(.LANE(i), .VL_W(VL_W), .REG_W(REG_W)) u_lane (
      .base(grp_base), .vl(cur_vl), .tag(cur_tag),
      .rd(cur_rd), .rs1(cur_rs1), .rs2(cur_rs2), .vsel(cur_vsel),
      .en(out_lane_en[i]),
      .idx(out_idx[i*VL_W +: VL_W]),
      .rd_o(out_rd[i*REG_W +: REG_W]),
      .rs1_o(out_rs1[i*REG_W +: REG_W]),
      .rs2_o(out_rs2[i*REG_W +: REG_W])
    );
  end
endmodule

// File: rtl/velem_seq_chk.sv
module velem_seq_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned VL_W  = 6,
  parameter int unsigned REG_W = 5,
  parameter int unsigned OPC_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [OPC_W-1:0]       out_opc,
  input logic [LANES-1:0]       out_lane_en,
  input logic [LANES*VL_W-1:0]  out_idx,
  input logic [LANES*REG_W-1:0] out_rd,
  input logic                   out_last,
  input logic                   pc_stall
);
  localparam logic [VL_W-1:0] STEP = VL_W'(LANES);
  logic [VL_W-1:0] idx0;
  assign idx0 = out_idx[VL_W-1:0];

  assert_stall_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall |-> out_valid);

  assert_stall_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pc_stall) |-> $past(out_valid && out_ready && out_last));

  assert_opc_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> $stable(out_opc));

  assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && idx0 == $past(idx0) + STEP));

  assert_lane_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_en[0] && ((out_lane_en & (out_lane_en + 1'b1)) == '0)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_lane_en)
                                   && $stable(out_rd) && $stable(out_last)));

  assert_in_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |-> !in_ready);
endmodule

bind velem_seq velem_seq_chk #(
  .LANES(LANES), .VL_W(VL_W), .REG_W(REG_W), .OPC_W(OPC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
  .out_lane_en(out_lane_en), .out_idx(out_idx), .out_rd(out_rd),
  .out_last(out_last), .pc_stall(pc_stall)
);

// File: tb/sim_velem_seq.sv
`timescale 1ns/1ps
module sim_velem_seq;
  localparam int L  = 4;
  localparam int VW = 6;
  localparam int RW = 5;
  localparam int OW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_tag;
  logic [VW-1:0] in_vl;
  logic [OW-1:0] in_opc;
  logic [RW-1:0] in_rd, in_rs1, in_rs2;
  logic [2:0]    in_vsel;
  logic out_valid, out_ready, out_last, pc_stall;
  logic [OW-1:0]   out_opc;
  logic [L-1:0]    out_lane_en;
  logic [L*VW-1:0] out_idx;
  logic [L*RW-1:0] out_rd, out_rs1, out_rs2;

  always #2.5 clk = ~clk;

  velem_seq #(.LANES(L), .VL_W(VW), .REG_W(RW), .OPC_W(OW)) u0 (.*);

  typedef struct {
    logic            tag;
    logic [L-1:0]    en;
    logic            last;
    logic [OW-1:0]   opc;
    logic [L*VW-1:0] idx;
    logic [L*RW-1:0] rd, rs1, rs2;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int ready_mode = 0;   // 0: always ready, 1: pseudo-random, 2: never ready
  logic [7:0] lfsr = 8'hA5;
  logic held = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: compute expected groups, then hand the instruction over
  task automatic send(input bit tag, input int vl, input logic [OW-1:0] opc,
                      input logic [RW-1:0] rd, input logic [RW-1:0] rs1,
                      input logic [RW-1:0] rs2, input logic [2:0] vsel);
    exp_t e;
    if (!tag) begin
      e.tag = 0; e.en = '0; e.en[0] = 1'b1; e.last = 1; e.opc = opc;
      e.idx = '0; e.rd = '0; e.rs1 = '0; e.rs2 = '0;
      e.rd[RW-1:0] = rd; e.rs1[RW-1:0] = rs1; e.rs2[RW-1:0] = rs2;
      q.push_back(e);
    end else begin
      for (int g = 0; g * L < vl; g++) begin
        e.tag = 1; e.opc = opc; e.en = '0;
        e.idx = '0; e.rd = '0; e.rs1 = '0; e.rs2 = '0;
        e.last = ((g + 1) * L >= vl);
        for (int i = 0; i < L; i++) begin
          int n = g * L + i;
          logic [RW-1:0] s = RW'(n);
          e.en[i] = (n < vl);
          e.idx[i*VW +: VW] = VW'(n);
          e.rd[i*RW +: RW]  = vsel[0] ? rd  + s : rd;
          e.rs1[i*RW +: RW] = vsel[1] ? rs1 + s : rs1;
          e.rs2[i*RW +: RW] = vsel[2] ? rs2 + s : rs2;
        end
        q.push_back(e);
      end
    end
    in_tag = tag; in_vl = VW'(vl); in_opc = opc;
    in_rd = rd; in_rs1 = rs1; in_rs2 = rs2; in_vsel = vsel;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // ready generator
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (ready_mode)
        1:       out_ready = lfsr[0];
        2:       out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R8", "group with nothing expected", out_idx, 0);
        end else begin
          string rq = held ? "R9" : "";
          chk(out_opc == q[0].opc, q[0].tag ? {"R4 ", rq} : {"R2 ", rq}, "opcode", out_opc, q[0].opc);
          chk(out_lane_en == q[0].en, {"R6 ", rq}, "lane enables", out_lane_en, q[0].en);
          chk(out_last == q[0].last, {"R6 ", rq}, "last flag", out_last, q[0].last);
          for (int i = 0; i < L; i++) begin
            if (q[0].en[i]) begin
              chk(out_idx[i*VW +: VW] == q[0].idx[i*VW +: VW], {"R5 ", rq}, "lane index",
                  out_idx[i*VW +: VW], q[0].idx[i*VW +: VW]);
              chk(out_rd[i*RW +: RW] == q[0].rd[i*RW +: RW], {"R7 ", rq}, "rd",
                  out_rd[i*RW +: RW], q[0].rd[i*RW +: RW]);
              chk(out_rs1[i*RW +: RW] == q[0].rs1[i*RW +: RW], {"R7 ", rq}, "rs1",
                  out_rs1[i*RW +: RW], q[0].rs1[i*RW +: RW]);
              chk(out_rs2[i*RW +: RW] == q[0].rs2[i*RW +: RW], {"R7 ", rq}, "rs2",
                  out_rs2[i*RW +: RW], q[0].rs2[i*RW +: RW]);
            end
          end
        end
      end
      // R3: stall follows tagged groups on the output
      chk(pc_stall == (out_valid && q.size() > 0 && q[0].tag), "R3", "pc_stall",
          pc_stall, out_valid && q.size() > 0 && q[0].tag);
      held = out_valid && !out_ready;
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    in_valid = 0; in_tag = 0; in_vl = '0; in_opc = '0;
    in_rd = '0; in_rs1 = '0; in_rs2 = '0; in_vsel = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(pc_stall == 0,  "R1", "pc_stall after reset", pc_stall, 0);
    chk(in_ready == 1,  "R1", "in_ready after reset", in_ready, 1);

    // R2: untagged pass-through, output in the next cycle
    @(posedge clk); #1;
    send(0, 0, 7'h21, 5'd3, 5'd4, 5'd5, 3'b111);
    @(negedge clk);
    // accepted at the previous edge; group valid now (monitor compares content)
    #0;
    repeat (3) @(posedge clk);

    // R5/R6/R7: partial final group, rd and rs2 vector
    send(1, 10, 7'h12, 5'd8, 5'd2, 5'd16, 3'b101);
    // exact multiple, only rs1 vector
    send(1, 8, 7'h33, 5'd1, 5'd9, 5'd0, 3'b010);
    send(1, 1, 7'h05, 5'd6, 5'd7, 5'd8, 3'b111);
    repeat (6) @(posedge clk);

    // R8: zero length issues nothing
    send(1, 0, 7'h44, 5'd1, 5'd1, 5'd1, 3'b111);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 0, "R8", "out_valid after zero length", out_valid, 0);
      chk(pc_stall == 0,  "R8", "pc_stall after zero length", pc_stall, 0);
      chk(in_ready == 1,  "R8", "in_ready after zero length", in_ready, 1);
    end

    // R9/R10: issue blocked downstream
    ready_mode = 2;
    @(posedge clk); #1;
    send(1, 9, 7'h5A, 5'd0, 5'd0, 5'd0, 3'b001);
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 0,  "R10", "in_ready while blocked", in_ready, 0);
      chk(pc_stall == 1,  "R3",  "pc_stall while blocked", pc_stall, 1);
    end
    ready_mode = 0;
    repeat (6) @(posedge clk);

    // random backpressure, back-to-back mix, register wrap (R7)
    ready_mode = 1;
    send(1, 13, 7'h6E, 5'd30, 5'd29, 5'd31, 3'b111);
    send(0, 0, 7'h01, 5'd10, 5'd11, 5'd12, 3'b000);
    send(0, 0, 7'h02, 5'd13, 5'd14, 5'd15, 3'b111);
    send(1, 3, 7'h03, 5'd20, 5'd21, 5'd22, 3'b110);
    send(1, 0, 7'h04, 5'd0, 5'd0, 5'd0, 3'b000);
    send(1, 63, 7'h7F, 5'd31, 5'd1, 5'd2, 3'b011);
    send(1, 5, 7'h15, 5'd4, 5'd4, 5'd4, 3'b100);
    while (q.size() != 0) @(posedge clk);
    ready_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(pc_stall == 0, "R3", "pc_stall at end", pc_stall, 0);
    chk(in_ready == 1, "R10", "in_ready at end", in_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule